// File: doc/BRIEF.md
# GPIO Output and Output-Enable Register Bank

This block holds the two words that drive a 32-pin general-purpose I/O port: the output value word and the output-enable word. Software reaches each word through three registers. A full-width register replaces every bit at once. Two half-width masked registers, one for the low half and one for the high half, carry a 16-bit write mask in their top half and 16 data bits in their bottom half. A masked write changes only the selected bits, so several agents can own different pins without a read-modify-write race.

Each of the six registers has its own write strobe and its own 32-bit data slice, already decoded by the bus front end. Reads are combinational from a 3-bit register index. The two words drive the pin output and pin enable signals straight from flops; a pin whose enable bit is 1 drives its output value, otherwise it stays a non-driving input.

Top module: `gpio_out_bank`

## Requirements
- R1: After reset both words are zero, so every pin output is 0 and every pin enable is 0 (non-driving).
- R2: A write to a full-width register (index 0 for output value, index 3 for enable) replaces all 32 bits of its word; the pins show the new value one clock after the strobe.
- R3: A low-half masked write (index 1 for output, 4 for enable) takes its mask from bits 31:16 and its data from bits 15:0, and sets word bit i (0..15) to data bit i only where mask bit i is 1; bits 31:16 of the word keep their value.
- R4: A high-half masked write (index 2 for output, 5 for enable) sets word bit 16+i to data bit i only where mask bit i is 1; bits 15:0 of the word keep their value.
- R5: A masked write whose mask is all zero leaves the target word unchanged.
- R6: Reading a masked register returns zero in bits 31:16 and the current low (index 1, 4) or high (index 2, 5) half of its word in bits 15:0.
- R7: Reading a full-width register returns the whole current word, including bits set by earlier masked writes.
- R8: When several registers of one word are strobed in the same cycle, the full write applies first, then the low masked write on its result, then the high masked write on that result.
- R9: Writes to the registers of one word never change the other word.
- R10: Reading register index 6 or 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_stb_i | input | 6 | Write strobe, one bit per register index 0..5 |
| wr_data_i | input | 192 | Write data, slice k*32 +: 32 belongs to register index k |
| rd_idx_i | input | 3 | Register index to read |
| rd_data_o | output | 32 | Read data for rd_idx_i |
| gpio_out_o | output | 32 | Pin output values |
| gpio_oe_o | output | 32 | Pin output enables, 1 = drive |

## Verification
Random stimulus strobes any subset of the six registers each cycle with random data, and a quarter of masked writes carry an all-zero mask; this separates correct per-bit masking from whole-half overwrites and shows any stray update under a zero mask. Cycles with several strobes on one word tell the fixed application order apart from any other order, since the high masked write can override bits the full write just set. Every cycle all eight read indices and both pin words are compared with a bench model, which exposes wrong half selection, non-zero upper read bits and cross-talk between the two words.

// File: rtl/gob_pkg.sv
package gob_pkg;
  // Register indices; strobe bit k and data slice k belong to index k.
  typedef enum logic [2:0] {
    IDX_OUT_ALL = 3'd0,
    IDX_OUT_LO  = 3'd1,
    IDX_OUT_HI  = 3'd2,
    IDX_OE_ALL  = 3'd3,
    IDX_OE_LO   = 3'd4,
    IDX_OE_HI   = 3'd5
  } gob_idx_e;

  localparam int unsigned REGS_PER_WORD = 3;
  localparam int unsigned NUM_WORDS     = 2;
  localparam int unsigned NUM_REGS      = REGS_PER_WORD * NUM_WORDS;
  localparam int unsigned IDX_W         = 3;
endpackage

// File: rtl/gob_word.sv
module gob_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         full_we_i,
  input  logic [W-1:0] full_wd_i,
  input  logic         lo_we_i,
  input  logic [W-1:0] lo_wd_i,
  input  logic         hi_we_i,
  input  logic [W-1:0] hi_wd_i,
  output logic [W-1:0] word_o
);
  localparam int unsigned H = W / 2;

  // Apply one masked half-write: mask in the top half of req, data in the bottom.
  function automatic logic [W-1:0] merge_half(input logic [W-1:0] cur,
                                               input logic [W-1:0] req,
                                               input logic upper);
    logic [H-1:0] msk, dat, old, nxt;
    logic [W-1:0] res;
    msk = req[W-1:H];
    dat = req[H-1:0];
    old = upper ? cur[W-1:H] : cur[H-1:0];
    nxt = (old & ~msk) | (dat & msk);
    res = cur;
    if (upper) res[W-1:H] = nxt;
    else       res[H-1:0] = nxt;
    return res;
  endfunction

  logic [W-1:0] word_q;
  logic [W-1:0] after_full;
  logic [W-1:0] after_lo;
  logic [W-1:0] word_d;
  logic         any_we;

  // Fixed order: full, then low half, then high half.
  assign after_full = full_we_i ? full_wd_i : word_q;
  assign after_lo   = lo_we_i ? merge_half(after_full, lo_wd_i, 1'b0) : after_full;
  assign word_d     = hi_we_i ? merge_half(after_lo, hi_wd_i, 1'b1) : after_lo;
  assign any_we     = full_we_i | lo_we_i | hi_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (any_we) word_q <= word_d;
  end

  assign word_o = word_q;

  // R2
  full_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_we_i && !lo_we_i && !hi_we_i) |=> (word_o == $past(full_wd_i)));

  // R3
  lo_keeps_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_we_i && !full_we_i && !hi_we_i) |=> $stable(word_o[W-1:H]));

  // R4
  hi_keeps_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && !full_we_i && !lo_we_i) |=> $stable(word_o[H-1:0]));

  // R5
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_we_i && (!lo_we_i || lo_wd_i[W-1:H] == '0) &&
     (!hi_we_i || hi_wd_i[W-1:H] == '0)) |=> $stable(word_o));

  // R8
  hi_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_we_i && hi_wd_i[W-1:H] == {H{1'b1}}) |=> (word_o[W-1:H] == $past(hi_wd_i[H-1:0])));
endmodule

// File: rtl/gob_rdmux.sv
module gob_rdmux #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]           out_word_i,
  input  logic [W-1:0]           oe_word_i,
  input  logic [gob_pkg::IDX_W-1:0] idx_i,
  output logic [W-1:0]           rd_data_o
);
  import gob_pkg::*;
  localparam int unsigned H = W / 2;

  // Masked registers read back one half, zero-extended.
  function automatic logic [W-1:0] half_view(input logic [W-1:0] word, input logic upper);
    return upper ? {{H{1'b0}}, word[W-1:H]} : {{H{1'b0}}, word[H-1:0]};
  endfunction

  always_comb begin
    unique case (gob_idx_e'(idx_i))
      IDX_OUT_ALL: rd_data_o = out_word_i;
      IDX_OUT_LO:  rd_data_o = half_view(out_word_i, 1'b0);
      IDX_OUT_HI:  rd_data_o = half_view(out_word_i, 1'b1);
      IDX_OE_ALL:  rd_data_o = oe_word_i;
      IDX_OE_LO:   rd_data_o = half_view(oe_word_i, 1'b0);
      IDX_OE_HI:   rd_data_o = half_view(oe_word_i, 1'b1);
      default:     rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [gob_pkg::NUM_REGS-1:0]           wr_stb_i,
  input  logic [gob_pkg::NUM_REGS*WIDTH-1:0]     wr_data_i,
  input  logic [gob_pkg::IDX_W-1:0]              rd_idx_i,
  output logic [WIDTH-1:0]                       rd_data_o,
  output logic [WIDTH-1:0]                       gpio_out_o,
  output logic [WIDTH-1:0]                       gpio_oe_o
);
  import gob_pkg::*;
  localparam int unsigned HALF = WIDTH / 2;

  logic [NUM_WORDS-1:0][WIDTH-1:0] words;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam int unsigned B = g * REGS_PER_WORD;
    gob_word #(.W(WIDTH)) u_word (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .full_we_i (wr_stb_i[B]),
      .full_wd_i (wr_data_i[B*WIDTH +: WIDTH]),
      .lo_we_i   (wr_stb_i[B+1]),
      .lo_wd_i   (wr_data_i[(B+1)*WIDTH +: WIDTH]),
      .hi_we_i   (wr_stb_i[B+2]),
      .hi_wd_i   (wr_data_i[(B+2)*WIDTH +: WIDTH]),
      .word_o    (words[g])
    );
  end

  gob_rdmux #(.W(WIDTH)) u_rdmux (
    .out_word_i (words[0]),
    .oe_word_i  (words[1]),
    .idx_i      (rd_idx_i),
    .rd_data_o  (rd_data_o)
  );

  assign gpio_out_o = words[0];
  assign gpio_oe_o  = words[1];

  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (gpio_out_o == '0 && gpio_oe_o == '0));

  // R6
  masked_read_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == 3'd1 || rd_idx_i == 3'd2 || rd_idx_i == 3'd4 || rd_idx_i == 3'd5)
      |-> (rd_data_o[WIDTH-1:HALF] == '0));

  // R7
  full_read_matches_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i == 3'd0) |-> (rd_data_o == gpio_out_o));

  // R9
  oe_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i[5:3] == 3'b000) |=> $stable(gpio_oe_o));

  // R9
  out_untouched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i[2:0] == 3'b000) |=> $stable(gpio_out_o));

  // R10
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_idx_i > 3'd5) |-> (rd_data_o == '0));
endmodule

// File: tb/sim_gpio_out_bank.sv
`timescale 1ns/1ps
module sim_gpio_out_bank;
  logic         clk = 0;
  logic         rst_n = 0;
  logic [5:0]   stb = '0;
  logic [191:0] wd = '0;
  logic [2:0]   ridx = '0;
  logic [31:0]  rdata, pout, poe;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m_out = '0;
  logic [31:0] m_oe  = '0;

  gpio_out_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_stb_i(stb), .wr_data_i(wd),
    .rd_idx_i(ridx), .rd_data_o(rdata), .gpio_out_o(pout), .gpio_oe_o(poe)
  );

  always #10 clk = ~clk;

  // Bench model: bit-by-bit, applied in the required order.
  function automatic logic [31:0] model_word(input logic [31:0] cur, input logic [2:0] we,
                                             input logic [31:0] a, input logic [31:0] l,
                                             input logic [31:0] h);
    logic [31:0] r = cur;
    if (we[0]) r = a;
    for (int i = 0; i < 16; i++) begin
      if (we[1] && l[16+i]) r[i] = l[i];
    end
    for (int i = 0; i < 16; i++) begin
      if (we[2] && h[16+i]) r[16+i] = h[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] model_read(input int k);
    case (k)
      0: return m_out;
      1: return {16'h0, m_out[15:0]};
      2: return {16'h0, m_out[31:16]};
      3: return m_oe;
      4: return {16'h0, m_oe[15:0]};
      5: return {16'h0, m_oe[31:16]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Check pins and every read index (R6 R7 R10 reads, R9 cross-word).
  task automatic check_all(input string req);
    chk({req, " pins out"}, pout, m_out);
    chk({req, " pins oe"}, poe, m_oe);
    for (int k = 0; k < 8; k++) begin
      ridx = 3'(k);
      #1;
      chk($sformatf("%s R6/R7/R10 read idx %0d", req, k), rdata, model_read(k));
    end
  endtask

  // Drive at the falling edge, commit at the rising edge, check just after.
  task automatic step(input logic [5:0] s, input logic [191:0] d, input string req);
    @(negedge clk);
    stb = s; wd = d;
    @(posedge clk);
    m_out = model_word(m_out, s[2:0], d[31:0], d[63:32], d[95:64]);
    m_oe  = model_word(m_oe,  s[5:3], d[127:96], d[159:128], d[191:160]);
    #1;
    stb = '0;
    check_all(req);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [191:0] d;
    void'($urandom(32'h5eed_0042));
    #25;
    // R1: reset state
    chk("R1 out", pout, 32'h0);
    chk("R1 oe", poe, 32'h0);
    rst_n = 1;
    @(posedge clk); #1;
    check_all("R1");

    // R2: full writes to both words
    d = '0; d[31:0] = 32'hA5A5_3C3C; d[127:96] = 32'h0F0F_F0F0;
    step(6'b001001, d, "R2");
    // R3: low masked write on output word
    d = '0; d[63:32] = 32'h00FF_1234;
    step(6'b000010, d, "R3");
    chk("R3 direct", pout, 32'hA5A5_3C34);
    // R4: high masked write on enable word
    d = '0; d[191:160] = 32'hF000_BEEF;
    step(6'b100000, d, "R4");
    chk("R4 direct", poe, 32'hBF0F_F0F0);
    // R5: zero masks on all four masked registers
    d = '0; d[63:32] = 32'h0000_FFFF; d[95:64] = 32'h0000_FFFF;
    d[159:128] = 32'h0000_FFFF; d[191:160] = 32'h0000_FFFF;
    step(6'b110110, d, "R5");
    chk("R5 out", pout, 32'hA5A5_3C34);
    // R8: all three of one word in one cycle
    d = '0; d[31:0] = 32'h1111_2222; d[63:32] = 32'h000F_000A; d[95:64] = 32'hFFFF_9999;
    step(6'b000111, d, "R8");
    chk("R8 order", pout, 32'h9999_222A);
    // R9: only output word written, enable must hold
    d = '0; d[31:0] = 32'hFFFF_FFFF;
    step(6'b000001, d, "R9");
    chk("R9 oe held", poe, 32'hBF0F_F0F0);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] s;
      s = 6'($urandom());
      for (int k = 0; k < 6; k++) begin
        logic [31:0] w;
        w = $urandom();
        if ((k % 3) != 0 && ($urandom() % 4) == 0) w[31:16] = 16'h0;
        d[k*32 +: 32] = w;
      end
      step(s, d, "R2/R3/R4/R5/R8/R9 random");
    end

    // R1: reset again mid-run
    @(negedge clk); rst_n = 0; #1;
    m_out = '0; m_oe = '0;
    chk("R1 rereset out", pout, 32'h0);
    chk("R1 rereset oe", poe, 32'h0);
    @(negedge clk); rst_n = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule